// File: doc/BRIEF.md
# ALU Operation Selector

This block sets the operation a processor's ALU performs. A 2-bit mode input comes from the main control. Two of the modes force a fixed operation, addition or subtraction. These serve address arithmetic and comparisons. The other two modes look at the instruction. Register-format instructions are decoded from their 6-bit function field, which is instruction bits 5:0. Immediate-format instructions are decoded from their 6-bit opcode, which is instruction bits 31:26.

The block is purely combinational. It gives a 4-bit operation code and a flag. The flag rises when the instruction field under decode has no mapping. In that case the operation code falls back to addition, so the datapath still sees a harmless operation.

Top module: `alu_op_select`

## Requirements
- R1: The mode encoding is 00 = add, 01 = subtract, 10 = register format, 11 = immediate format. In mode 00 the output is ADD (0000) and the flag is 0, whatever the function and opcode inputs hold.
- R2: In mode 01 the output is SUB (0001) and the flag is 0, whatever the function and opcode inputs hold.
- R3: In mode 10, function codes 100000 and 100001 give ADD (0000), and 100010 and 100011 give SUB (0001). The flag is 0 for all four.
- R4: In mode 10, function codes 100100, 100101, 100110 and 100111 give AND (0010), OR (0011), XOR (0100) and NOR (0101) respectively. The flag is 0 for all four.
- R5: In mode 10, function code 101010 gives signed set-less-than SLT (0110), and 101011 gives unsigned set-less-than SLTU (0111). The flag is 0 for both.
- R6: In mode 10, the shift function codes map as follows, with the flag at 0:
  - 000000 and 000100 give SLL (1000).
  - 000010 and 000110 give SRL (1001).
  - 000011 and 000111 give SRA (1010).
- R7: In mode 11, opcodes 001000 and 001001 give ADD (0000), 001010 gives SLT (0110) and 001011 gives SLTU (0111). The flag is 0 for all four.
- R8: In mode 11, opcodes 001100, 001101, 001110 and 001111 give AND (0010), OR (0011), XOR (0100) and PASSB (1011) respectively. PASSB means "pass operand B". The flag is 0 for all four.
- R9: In mode 10, any function code not listed above gives ADD (0000) with the flag at 1. In mode 11, any opcode not listed above gives ADD (0000) with the flag at 1.
- R10: In mode 10 the opcode input has no effect on either output. In mode 11 the function input has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 2 | Selects add, subtract, register-format or immediate-format behaviour |
| funct | input | 6 | Function field, instruction bits 5:0 |
| opcode | input | 6 | Opcode field, instruction bits 31:26 |
| alu_op | output | 4 | Operation code sent to the ALU |
| unsupported | output | 1 | High when the decoded field has no mapping |

## Verification
The assertions check several rules on every input change:
- Both fixed modes yield their fixed code with the flag low.
- A raised flag always comes with the add code.
- A shift-class function code always yields a shift operation.
- The whole immediate-arithmetic opcode group is accepted.

The exact code for each listed function value and opcode can only be shown by the bench's scenarios, which compare each value against a table written separately from the design. The same holds for the complete sweeps showing that every unlisted value is flagged, and for the demonstration that the field outside the current mode has no effect.

// File: rtl/alu_op_pkg.sv
package alu_op_pkg;
  localparam int MODE_W  = 2;
  localparam int FIELD_W = 6;
  localparam int OP_W    = 4;
  localparam int GRP_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_ADD  = 2'b00,
    MODE_SUB  = 2'b01,
    MODE_RFMT = 2'b10,
    MODE_IFMT = 2'b11
  } mode_e;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'b0000,
    OP_SUB   = 4'b0001,
    OP_AND   = 4'b0010,
    OP_OR    = 4'b0011,
    OP_XOR   = 4'b0100,
    OP_NOR   = 4'b0101,
    OP_SLT   = 4'b0110,
    OP_SLTU  = 4'b0111,
    OP_SLL   = 4'b1000,
    OP_SRL   = 4'b1001,
    OP_SRA   = 4'b1010,
    OP_PASSB = 4'b1011
  } aluop_e;

  typedef struct packed {
    aluop_e op;
    logic   bad;
  } dec_t;

  // Group codes taken from the top three bits of a field
  localparam logic [GRP_W-1:0] GRP_SHIFT = 3'b000;
  localparam logic [GRP_W-1:0] GRP_IMM   = 3'b001;
  localparam logic [GRP_W-1:0] GRP_ARITH = 3'b100;
  localparam logic [GRP_W-1:0] GRP_CMP   = 3'b101;

  // Shift kind from the low two bits; bit 2 marks the register-amount form
  function automatic dec_t shift_kind(logic [GRP_W-1:0] low);
    dec_t r;
    r.op  = OP_ADD;
    r.bad = 1'b0;
    unique case (low[1:0])
      2'b00:   r.op = OP_SLL;
      2'b10:   r.op = OP_SRL;
      2'b11:   r.op = OP_SRA;
      default: r.bad = 1'b1;
    endcase
    return r;
  endfunction

  // Shared arithmetic/logic row: pairs map to add/sub, then the four logic ops
  function automatic aluop_e arith_row(logic [GRP_W-1:0] low);
    aluop_e o;
    unique case (low)
      3'b000, 3'b001: o = OP_ADD;
      3'b010, 3'b011: o = OP_SUB;
      3'b100:         o = OP_AND;
      3'b101:         o = OP_OR;
      3'b110:         o = OP_XOR;
      default:        o = OP_NOR;
    endcase
    return o;
  endfunction

  function automatic dec_t decode_funct(logic [FIELD_W-1:0] f);
    dec_t r;
    r.op  = OP_ADD;
    r.bad = 1'b0;
    unique case (f[FIELD_W-1:FIELD_W-GRP_W])
      GRP_SHIFT: r = shift_kind(f[GRP_W-1:0]);
      GRP_ARITH: r.op = arith_row(f[GRP_W-1:0]);
      GRP_CMP: begin
        unique case (f[GRP_W-1:0])
          3'b010:  r.op = OP_SLT;
          3'b011:  r.op = OP_SLTU;
          default: r.bad = 1'b1;
        endcase
      end
      default: r.bad = 1'b1;
    endcase
    if (r.bad) r.op = OP_ADD;
    return r;
  endfunction

  function automatic dec_t decode_opcode(logic [FIELD_W-1:0] c);
    dec_t r;
    r.op  = OP_ADD;
    r.bad = 1'b0;
    if (c[FIELD_W-1:FIELD_W-GRP_W] == GRP_IMM) begin
      unique case (c[GRP_W-1:0])
        3'b000, 3'b001: r.op = OP_ADD;
        3'b010:         r.op = OP_SLT;
        3'b011:         r.op = OP_SLTU;
        3'b111:         r.op = OP_PASSB;
        default:        r.op = arith_row(c[GRP_W-1:0]);
      endcase
    end else begin
      r.bad = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/funct_field_decoder.sv
module funct_field_decoder
  import alu_op_pkg::*;
(
  input  logic [FIELD_W-1:0] funct,
  output aluop_e             op,
  output logic               bad,
  output logic               shift_class
);
  dec_t res;

  always_comb begin
    res         = decode_funct(funct);
    op          = res.op;
    bad         = res.bad;
    shift_class = (funct[FIELD_W-1:FIELD_W-GRP_W] == GRP_SHIFT) && (funct[1:0] != 2'b01);
  end

  always_comb begin
    if (shift_class)
      AST_SHIFT_CLASS: assert (op == OP_SLL || op == OP_SRL || op == OP_SRA); // R6
    if (bad)
      AST_FN_BAD_ADD: assert (op == OP_ADD); // R9
  end
endmodule

// File: rtl/opcode_field_decoder.sv
module opcode_field_decoder
  import alu_op_pkg::*;
(
  input  logic [FIELD_W-1:0] opcode,
  output aluop_e             op,
  output logic               bad,
  output logic               imm_group
);
  dec_t res;

  always_comb begin
    res       = decode_opcode(opcode);
    op        = res.op;
    bad       = res.bad;
    imm_group = (opcode[FIELD_W-1:FIELD_W-GRP_W] == GRP_IMM);
  end

  always_comb begin
    if (imm_group)
      AST_IMM_ACCEPTED: assert (!bad && op != OP_SUB && op != OP_NOR); // R7
    if (!imm_group)
      AST_OC_BAD_ADD: assert (bad && op == OP_ADD); // R9
  end
endmodule

// File: rtl/mode_steer.sv
module mode_steer
  import alu_op_pkg::*;
(
  input  mode_e  mode,
  input  aluop_e fn_op,
  input  logic   fn_bad,
  input  aluop_e oc_op,
  input  logic   oc_bad,
  output aluop_e op,
  output logic   bad
);
  always_comb begin
    op  = OP_ADD;
    bad = 1'b0;
    unique case (mode)
      MODE_ADD:  op = OP_ADD;
      MODE_SUB:  op = OP_SUB;
      MODE_RFMT: begin op = fn_op; bad = fn_bad; end
      default:   begin op = oc_op; bad = oc_bad; end
    endcase
  end
endmodule

// File: rtl/alu_op_select.sv
module alu_op_select
  import alu_op_pkg::*;
(
  input  logic [MODE_W-1:0]  mode,
  input  logic [FIELD_W-1:0] funct,
  input  logic [FIELD_W-1:0] opcode,
  output logic [OP_W-1:0]    alu_op,
  output logic               unsupported
);
  aluop_e fn_op, oc_op, sel_op;
  logic   fn_bad, oc_bad, sel_bad;
  logic   fn_shift, oc_imm;

  funct_field_decoder u_fn (
    .funct(funct), .op(fn_op), .bad(fn_bad), .shift_class(fn_shift)
  );

  opcode_field_decoder u_oc (
    .opcode(opcode), .op(oc_op), .bad(oc_bad), .imm_group(oc_imm)
  );

  mode_steer u_steer (
    .mode(mode_e'(mode)), .fn_op(fn_op), .fn_bad(fn_bad),
    .oc_op(oc_op), .oc_bad(oc_bad), .op(sel_op), .bad(sel_bad)
  );

  assign alu_op      = sel_op;
  assign unsupported = sel_bad;

  always_comb begin
    if (mode == MODE_ADD)
      AST_ADD_MODE: assert (alu_op == OP_ADD && !unsupported); // R1
    if (mode == MODE_SUB)
      AST_SUB_MODE: assert (alu_op == OP_SUB && !unsupported); // R2
    if (unsupported)
      AST_UNSUP_IS_ADD: assert (alu_op == OP_ADD); // R9
    if (mode == MODE_RFMT && fn_shift)
      AST_RFMT_SHIFT_OK: assert (!unsupported); // R6
    if (mode == MODE_IFMT && oc_imm)
      AST_IFMT_GROUP_OK: assert (!unsupported); // R8
  end
endmodule

// File: tb/alu_op_select_test.sv
module alu_op_select_test;
  logic       clk = 1'b0;
  logic [1:0] mode;
  logic [5:0] funct, opcode;
  logic [3:0] alu_op;
  logic       unsupported;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_op_select uut (
    .mode(mode), .funct(funct), .opcode(opcode),
    .alu_op(alu_op), .unsupported(unsupported)
  );

  // Independent expectation tables: {flag, code}
  function automatic logic [4:0] exp_r(logic [5:0] f);
    case (f)
      6'h20, 6'h21: return 5'h00;
      6'h22, 6'h23: return 5'h01;
      6'h24: return 5'h02;
      6'h25: return 5'h03;
      6'h26: return 5'h04;
      6'h27: return 5'h05;
      6'h2A: return 5'h06;
      6'h2B: return 5'h07;
      6'h00, 6'h04: return 5'h08;
      6'h02, 6'h06: return 5'h09;
      6'h03, 6'h07: return 5'h0A;
      default: return 5'h10;
    endcase
  endfunction

  function automatic logic [4:0] exp_i(logic [5:0] c);
    case (c)
      6'h08, 6'h09: return 5'h00;
      6'h0A: return 5'h06;
      6'h0B: return 5'h07;
      6'h0C: return 5'h02;
      6'h0D: return 5'h03;
      6'h0E: return 5'h04;
      6'h0F: return 5'h0B;
      default: return 5'h10;
    endcase
  endfunction

  task automatic apply(input logic [1:0] m, input logic [5:0] f, input logic [5:0] c);
    @(negedge clk);
    mode = m; funct = f; opcode = c;
    #2;
  endtask

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if ({unsupported, alu_op} !== exp) begin
      errors++;
      $display("FAIL %s mode=%b funct=%b opcode=%b got=%b/%h exp=%b/%h",
               req, mode, funct, opcode, unsupported, alu_op, exp[4], exp[3:0]);
    end
  endtask

  task automatic t_fixed_modes();
    for (int k = 0; k < 8; k++) begin
      apply(2'b00, 6'(k * 9), 6'(63 - k * 7));
      check("R1", 5'h00);
      apply(2'b01, 6'(k * 11), 6'(k * 5));
      check("R2", 5'h01);
    end
  endtask

  task automatic t_rfmt_listed();
    apply(2'b10, 6'h20, 6'h00); check("R3", exp_r(6'h20));
    apply(2'b10, 6'h23, 6'h3F); check("R3", exp_r(6'h23));
    apply(2'b10, 6'h24, 6'h00); check("R4", 5'h02);
    apply(2'b10, 6'h27, 6'h00); check("R4", 5'h05);
    apply(2'b10, 6'h2A, 6'h00); check("R5", 5'h06);
    apply(2'b10, 6'h2B, 6'h00); check("R5", 5'h07);
    apply(2'b10, 6'h04, 6'h00); check("R6", 5'h08);
    apply(2'b10, 6'h07, 6'h00); check("R6", 5'h0A);
  endtask

  task automatic t_rfmt_sweep();
    for (int v = 0; v < 64; v++) begin
      apply(2'b10, 6'(v), 6'(v ^ 6'h15));
      check(exp_r(6'(v))[4] ? "R9" : "R3", exp_r(6'(v)));
    end
  endtask

  task automatic t_ifmt_sweep();
    for (int v = 0; v < 64; v++) begin
      apply(2'b11, 6'(v ^ 6'h2A), 6'(v));
      check(exp_i(6'(v))[4] ? "R9" : ((v & 4) != 0 ? "R8" : "R7"), exp_i(6'(v)));
    end
    apply(2'b11, 6'h20, 6'h0F); check("R8", 5'h0B);
    apply(2'b11, 6'h20, 6'h09); check("R7", 5'h00);
  endtask

  task automatic t_ignored_field();
    for (int v = 0; v < 64; v += 7) begin
      apply(2'b10, 6'h26, 6'(v));
      check("R10", 5'h04);
      apply(2'b11, 6'(v), 6'h0D);
      check("R10", 5'h03);
    end
  endtask

  initial begin
    mode = 2'b00; funct = 6'h00; opcode = 6'h00;
    #12;
    check("R1", 5'h00);
    t_fixed_modes();
    t_rfmt_listed();
    t_rfmt_sweep();
    t_ifmt_sweep();
    t_ignored_field();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule